// File: doc/BRIEF.md
# Program and Data Memory Router

This block sits between an 8051-style core and its memories. Each program fetch or data-memory access goes either to on-chip storage or to an expanded external bus. The choice depends on one comparison: the access address against a configurable on-chip size for that address space. Program space and data space each have their own size, and each starts at address zero and runs without gaps up to that size. An address below the size is served on-chip. An address at or above it runs an external cycle on two byte-wide ports. The low port carries the address low byte and then the data, and a latch-enable pulse marks the address phase. The high port carries the address high byte. One of three active-low strobes enables the external device: a code-read strobe for program fetches, a read strobe for data reads, and a write strobe for data writes.

Requests arrive on a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the router is idle. The core must hold the request fields stable until it is accepted. Each accepted request produces exactly one response beat. `rsp_valid` stays high, and the beat's contents stay unchanged, until the core raises `rsp_ready`. No new request is accepted until that beat is consumed.

The two ports belong to the bus only while an external access is in flight. At all other times, including during on-chip accesses, they carry the core's general-purpose I/O values and per-bit enables unchanged. Program space is read-only: a write flag that comes with a program fetch is ignored.

Top module: `mem_router`

## Requirements
- R1: While reset is asserted and right after it, `req_ready`=1, `rsp_valid`=0, `ale`=0, `int_en`=0 and `psen_n`=`rd_n`=`wr_n`=1, and both ports carry the I/O values.
- R2: A program fetch (`req_code`=1) whose address is below `code_size` goes on-chip (`int_en` with `int_code`=1, `rsp_ext`=0). Otherwise it goes external with `rsp_ext`=1. With `code_size`=0, every fetch goes external, including address 0000h.
- R3: A data access (`req_code`=0) whose address is below `data_size` goes on-chip (`int_code`=0). Otherwise it goes external. With a 1 KB size, 03FFh is on-chip and 0400h is external.
- R4: An external access takes four cycles after acceptance. Cycle 1 is the address phase: `ale`=1, the low port drives address bits 7:0 and the high port drives bits 15:8. Cycles 2 and 3 are the strobe phase. Cycle 4 is the response, with all strobes high. The high port holds the address byte from cycle 1 through cycle 4.
- R5: During the strobe phase exactly one strobe is low: `psen_n` for a fetch, `rd_n` for a data read, `wr_n` for a data write. At all other times all three are high.
- R6: For an external write, the low port drives `req_wdata` with all enables on during both strobe cycles. For an external read, the low port enables are off during the strobe and response cycles, and `rsp_rdata` is the `p0_in` value present in the second strobe cycle.
- R7: The ports carry the bus (both enables all-ones in the address phase, high-port enables all-ones throughout) only during the four external cycles. Otherwise `p0_out`/`p0_oe` equal `gpio0_out`/`gpio0_oe` and `p2_out`/`p2_oe` equal `gpio2_out`/`gpio2_oe`.
- R8: An on-chip access pulses `int_en` for one cycle, the cycle after acceptance, carrying the address, the `int_code` space flag, the write enable and the write data. `int_rdata` is sampled in the following cycle, and the response is valid in the cycle after that. A write returns `rsp_rdata`=0.
- R9: `req_ready`=1 only when idle. `rsp_valid`, `rsp_rdata` and `rsp_ext` hold until the edge where `rsp_ready`=1. A request held valid during a busy period is taken only once the router is idle again.
- R10: A program fetch with `req_write`=1 behaves as a plain fetch: `wr_n` stays high, `int_we`=0, and `psen_n` or on-chip code space is used.
- R11: The boundary is exact. An address equal to size-1 is on-chip and an address equal to size is external. A size of 65536 keeps every address in that space on-chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_size | input | 17 | On-chip program bytes (0 to 65536) |
| data_size | input | 17 | On-chip data bytes (0 to 65536) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Router idle, request taken this edge |
| req_code | input | 1 | 1 = program fetch, 0 = data access |
| req_write | input | 1 | Data write (ignored for fetches) |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Core takes response |
| rsp_rdata | output | 8 | Read data (0 for writes) |
| rsp_ext | output | 1 | 1 = access went external |
| int_en | output | 1 | On-chip memory enable |
| int_code | output | 1 | On-chip space: 1 program, 0 data |
| int_we | output | 1 | On-chip write enable |
| int_addr | output | 16 | On-chip address |
| int_wdata | output | 8 | On-chip write data |
| int_rdata | input | 8 | On-chip read data, one cycle after `int_en` |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | External code-read strobe |
| rd_n | output | 1 | External data-read strobe |
| wr_n | output | 1 | External data-write strobe |
| p0_out | output | 8 | Low port output value |
| p0_oe | output | 8 | Low port per-bit output enable |
| p0_in | input | 8 | Low port pin value |
| p2_out | output | 8 | High port output value |
| p2_oe | output | 8 | High port per-bit output enable |
| gpio0_out | input | 8 | Core I/O value for low port |
| gpio0_oe | input | 8 | Core I/O enable for low port |
| gpio2_out | input | 8 | Core I/O value for high port |
| gpio2_oe | input | 8 | Core I/O enable for high port |

## Verification
The hardest case to reach is an external response that the core holds off, while the I/O inputs keep changing underneath it. In that window the ports must stay with the bus, the strobes must stay high, and the read data must stay frozen. None of that is visible unless the hold lasts several cycles. The stimulus stalls `rsp_ready` for several cycles on both external and on-chip accesses, and changes the I/O values and enables on every cycle. The boundary cases come from placing addresses at size-1 and size for 16 KB, 1 KB, zero and 65536 sizes. A request is also held valid across busy periods to show that it is taken only once per idle slot.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_DATA,
    ST_IREQ,
    ST_IWAIT,
    ST_DONE
  } rt_state_e;
endpackage

// File: rtl/mrt_decode.sv
module mrt_decode #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          code,
  input  logic [AW:0]   code_size,
  input  logic [AW:0]   data_size,
  output logic          internal
);
  localparam logic [AW:0] FULL = {1'b1, {AW{1'b0}}};

  always_comb begin
    logic [AW:0] limit;
    limit    = code ? code_size : data_size;
    internal = ({1'b0, addr} < limit);
    // a zero program size sends every fetch out
    if (code && code_size == '0)
      p_zero_code_r2: assert (!internal);
    // a full-size data space keeps every address on-chip
    if (!code && data_size == FULL)
      p_full_data_r11: assert (internal);
  end
endmodule

// File: rtl/mrt_seq.sv
module mrt_seq
  import mrt_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_code,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          is_int,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_ext,
  output logic          int_en,
  output logic          int_code,
  output logic          int_we,
  output logic [AW-1:0] int_addr,
  output logic [DW-1:0] int_wdata,
  input  logic [DW-1:0] int_rdata,
  output logic          bus_own,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] bus_lo,
  output logic          bus_lo_oe,
  output logic [AW-DW-1:0] bus_hi,
  input  logic [DW-1:0] p0_in
);
  rt_state_e     state;
  logic          r_code, r_write, r_ext;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_wdata, r_rdata;
  logic          strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      r_code  <= 1'b0;
      r_write <= 1'b0;
      r_ext   <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_rdata <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          r_code  <= req_code;
          r_write <= req_write & ~req_code;  // program space is read-only
          r_addr  <= req_addr;
          r_wdata <= req_wdata;
          r_ext   <= ~is_int;
          state   <= is_int ? ST_IREQ : ST_ADDR;
        end
        ST_ADDR:  state <= ST_STRB;
        ST_STRB:  state <= ST_DATA;
        ST_DATA: begin
          r_rdata <= r_write ? '0 : p0_in;
          state   <= ST_DONE;
        end
        ST_IREQ:  state <= ST_IWAIT;
        ST_IWAIT: begin
          r_rdata <= r_write ? '0 : int_rdata;
          state   <= ST_DONE;
        end
        ST_DONE:  if (rsp_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign strobe    = (state == ST_STRB) || (state == ST_DATA);
  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_DONE);
  assign rsp_rdata = r_rdata;
  assign rsp_ext   = r_ext;

  assign int_en    = (state == ST_IREQ);
  assign int_code  = r_code;
  assign int_we    = (state == ST_IREQ) && r_write;
  assign int_addr  = r_addr;
  assign int_wdata = r_wdata;

  assign bus_own   = (state == ST_ADDR) || strobe || ((state == ST_DONE) && r_ext);
  assign ale       = (state == ST_ADDR);
  assign psen_n    = ~(strobe & r_code);
  assign rd_n      = ~(strobe & ~r_code & ~r_write);
  assign wr_n      = ~(strobe & r_write);
  assign bus_lo    = (state == ST_ADDR) ? r_addr[DW-1:0] : r_wdata;
  assign bus_lo_oe = (state == ST_ADDR) || (strobe && r_write);
  assign bus_hi    = r_addr[AW-1:DW];

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
  p_ale_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));
  p_hi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $stable(bus_hi));
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_ext)));
  p_int_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_en |-> !bus_own);
endmodule

// File: rtl/mrt_portmux.sv
module mrt_portmux #(
  parameter int DW = 8,
  parameter int NP = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_own,
  input  logic [NP-1:0][DW-1:0]  bus_val,
  input  logic [NP-1:0]          bus_oe,
  input  logic [NP-1:0][DW-1:0]  gpio_val,
  input  logic [NP-1:0][DW-1:0]  gpio_oe,
  output logic [NP-1:0][DW-1:0]  pin_val,
  output logic [NP-1:0][DW-1:0]  pin_oe
);
  for (genvar i = 0; i < NP; i++) begin : g_port
    assign pin_val[i] = bus_own ? bus_val[i] : gpio_val[i];
    assign pin_oe[i]  = bus_own ? {DW{bus_oe[i]}} : gpio_oe[i];

    p_gpio_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_own |-> (pin_oe[i] == gpio_oe[i] && pin_val[i] == gpio_val[i]));
  end
endmodule

// File: rtl/mem_router.sv
module mem_router #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*DW:0]     code_size,
  input  logic [2*DW:0]     data_size,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_code,
  input  logic              req_write,
  input  logic [2*DW-1:0]   req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  output logic              rsp_ext,
  output logic              int_en,
  output logic              int_code,
  output logic              int_we,
  output logic [2*DW-1:0]   int_addr,
  output logic [DW-1:0]     int_wdata,
  input  logic [DW-1:0]     int_rdata,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DW-1:0]     p0_out,
  output logic [DW-1:0]     p0_oe,
  input  logic [DW-1:0]     p0_in,
  output logic [DW-1:0]     p2_out,
  output logic [DW-1:0]     p2_oe,
  input  logic [DW-1:0]     gpio0_out,
  input  logic [DW-1:0]     gpio0_oe,
  input  logic [DW-1:0]     gpio2_out,
  input  logic [DW-1:0]     gpio2_oe
);
  localparam int AW = 2 * DW;
  localparam int NP = 2;

  logic                  is_int, bus_own, bus_lo_oe;
  logic [DW-1:0]         bus_lo, bus_hi;
  logic [NP-1:0][DW-1:0] pin_val, pin_oe;

  mrt_decode #(.AW(AW)) u_dec (
    .addr(req_addr), .code(req_code),
    .code_size(code_size), .data_size(data_size), .internal(is_int)
  );

  mrt_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_code(req_code),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .is_int(is_int),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_ext(rsp_ext),
    .int_en(int_en), .int_code(int_code), .int_we(int_we), .int_addr(int_addr),
    .int_wdata(int_wdata), .int_rdata(int_rdata),
    .bus_own(bus_own), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .bus_lo(bus_lo), .bus_lo_oe(bus_lo_oe), .bus_hi(bus_hi), .p0_in(p0_in)
  );

  mrt_portmux #(.DW(DW), .NP(NP)) u_mux (
    .clk(clk), .rst_n(rst_n), .bus_own(bus_own),
    .bus_val({bus_hi, bus_lo}), .bus_oe({1'b1, bus_lo_oe}),
    .gpio_val({gpio2_out, gpio0_out}), .gpio_oe({gpio2_oe, gpio0_oe}),
    .pin_val(pin_val), .pin_oe(pin_oe)
  );

  assign p0_out = pin_val[0];
  assign p0_oe  = pin_oe[0];
  assign p2_out = pin_val[1];
  assign p2_oe  = pin_oe[1];
endmodule

// File: tb/mem_router_test.sv
module mem_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [16:0] code_size = 17'h04000;
  logic [16:0] data_size = 17'h00400;
  logic        req_valid = 1'b0, req_code = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, rsp_ext;
  logic [7:0]  rsp_rdata;
  logic        int_en, int_code, int_we;
  logic [15:0] int_addr;
  logic [7:0]  int_wdata;
  logic [7:0]  int_rdata = '0;
  logic        ale, psen_n, rd_n, wr_n;
  logic [7:0]  p0_out, p0_oe, p2_out, p2_oe;
  logic [7:0]  p0_in = 8'hEE;
  logic [7:0]  gpio0_out = '0, gpio0_oe = '0, gpio2_out = '0, gpio2_oe = '0;

  mem_router uut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  function automatic logic [7:0] ic(logic [15:0] a); return a[7:0] ^ a[15:8] ^ 8'h3C; endfunction
  function automatic logic [7:0] ec(logic [15:0] a); return a[7:0] + a[15:8] + 8'h91; endfunction

  // memory models driven from pins, and shadow copies kept by the reference model
  logic [7:0] mem_int[int], mem_ext[int], sh_int[int], sh_ext[int];
  function automatic logic [7:0] get_mi(int a); return mem_int.exists(a) ? mem_int[a] : 8'(a) ^ 8'hA5; endfunction
  function automatic logic [7:0] get_me(int a); return mem_ext.exists(a) ? mem_ext[a] : 8'(a) ^ 8'h5A; endfunction
  function automatic logic [7:0] get_si(int a); return sh_int.exists(a) ? sh_int[a] : 8'(a) ^ 8'hA5; endfunction
  function automatic logic [7:0] get_se(int a); return sh_ext.exists(a) ? sh_ext[a] : 8'(a) ^ 8'h5A; endfunction

  logic [7:0] lat_lo = '0;
  initial forever begin
    @(negedge clk);
    if (ale) lat_lo = p0_out;
    if (!wr_n) mem_ext[int'({p2_out, lat_lo})] = p0_out;
    if (!psen_n) p0_in = ec({p2_out, lat_lo});
    else if (!rd_n) p0_in = get_me(int'({p2_out, lat_lo}));
    else p0_in = 8'hEE;
    if (int_en) begin
      if (int_code) int_rdata = ic(int_addr);
      else int_rdata = get_mi(int'(int_addr));
      if (int_we) mem_int[int'(int_addr)] = int_wdata;
    end
  end

  // I/O values change every cycle
  initial begin
    int n = 0;
    forever begin
      @(negedge clk); #1;
      n++;
      gpio0_out = 8'(n * 29 + 3);
      gpio0_oe  = 8'(n * 53);
      gpio2_out = 8'(n * 71 + 9);
      gpio2_oe  = 8'(~(n * 17));
    end
  end

  // reference model: phase 0 idle, 1..4 external, 5..7 on-chip
  int          ph = 0;
  logic        m_code = 0, m_write = 0, m_wflag = 0, m_bound = 0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wdata = '0, m_rdata = '0;
  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else case (ph)
      0: if (req_valid) begin
        logic [16:0] lim;
        logic        m_int;
        m_code  = req_code;
        m_wflag = req_write;
        m_write = req_write && !req_code;
        m_addr  = req_addr;
        m_wdata = req_wdata;
        lim     = req_code ? code_size : data_size;
        m_int   = {1'b0, req_addr} < lim;
        m_bound = ({1'b0, req_addr} + 17'd1 == lim) || ({1'b0, req_addr} == lim) ||
                  lim == 17'h10000 || lim == 17'h0;
        if (m_write) begin
          if (m_int) sh_int[int'(m_addr)] = m_wdata; else sh_ext[int'(m_addr)] = m_wdata;
          m_rdata = 8'h00;
        end else if (m_code) m_rdata = m_int ? ic(m_addr) : ec(m_addr);
        else m_rdata = m_int ? get_si(int'(m_addr)) : get_se(int'(m_addr));
        ph = m_int ? 5 : 1;
      end
      1: ph = 2;
      2: ph = 3;
      3: ph = 4;
      4: if (rsp_ready) ph = 0;
      5: ph = 6;
      6: ph = 7;
      7: if (rsp_ready) ph = 0;
      default: ph = 0;
    endcase
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every output on every falling edge
  always @(negedge clk) if (!finished) begin
    bit ext, strb, rv, lo_oe;
    string rt, rs, rp;
    ext   = ph >= 1 && ph <= 4;
    strb  = ph == 2 || ph == 3;
    rv    = ph == 4 || ph == 7;
    lo_oe = ph == 1 || (strb && m_write);
    rt = m_bound ? "R11" : (m_code ? "R2" : "R3");
    rs = (m_code && m_wflag) ? "R10" : "R5";
    rp = "R7";
    if (!rst_n || ph == 0) begin rs = rst_n ? "R5" : "R1"; if (!rst_n) rp = "R1"; end
    chk(rst_n ? "R9" : "R1", "req_ready", req_ready, ph == 0);
    chk(rst_n ? "R9" : "R1", "rsp_valid", rsp_valid, rv);
    if (rv) begin
      chk(rt, "rsp_ext", rsp_ext, ph == 4);
      chk(ph == 4 ? "R6" : "R8", "rsp_rdata", rsp_rdata, m_rdata);
    end
    chk(rst_n ? "R4" : "R1", "ale", ale, ph == 1);
    chk(rs, "psen_n", psen_n, !(strb && m_code));
    chk(rs, "rd_n", rd_n, !(strb && !m_code && !m_write));
    chk(rs, "wr_n", wr_n, !(strb && m_write));
    if (ext) begin
      chk("R7", "p0_oe", p0_oe, lo_oe ? 8'hFF : 8'h00);
      chk("R7", "p2_oe", p2_oe, 8'hFF);
      chk("R4", "p2_out", p2_out, m_addr[15:8]);
      if (ph == 1) chk("R4", "p0_out addr", p0_out, m_addr[7:0]);
      else if (lo_oe) chk("R6", "p0_out wdata", p0_out, m_wdata);
    end else begin
      chk(rp, "p0_out", p0_out, gpio0_out);
      chk(rp, "p0_oe", p0_oe, gpio0_oe);
      chk(rp, "p2_out", p2_out, gpio2_out);
      chk(rp, "p2_oe", p2_oe, gpio2_oe);
    end
    chk(rst_n ? "R8" : "R1", "int_en", int_en, ph == 5);
    if (ph == 5) begin
      chk(rt, "int_code", int_code, m_code);
      chk(m_wflag && m_code ? "R10" : "R8", "int_we", int_we, m_write);
      chk("R8", "int_addr", int_addr, m_addr);
      if (m_write) chk("R8", "int_wdata", int_wdata, m_wdata);
    end
  end

  task automatic send(logic code, logic wr, logic [15:0] a, logic [7:0] d, int stall);
    @(negedge clk); #1;
    req_valid = 1'b1; req_code = code; req_write = wr; req_addr = a; req_wdata = d;
    rsp_ready = (stall == 0);
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk); #1;
    req_valid = 1'b0;
    while (!rsp_valid) begin @(negedge clk); #1; end
    repeat (stall) @(negedge clk);
    #1 rsp_ready = 1'b1;
    @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;                      // R1 reset state compared each cycle
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2 / R11: 16 KB program space
    send(1, 0, 16'h0000, 0, 0);
    send(1, 0, 16'h3FFF, 0, 0);
    send(1, 0, 16'h4000, 0, 0);
    send(1, 0, 16'hFFFF, 0, 0);
    // R3 / R6 / R11: 1 KB data space, reads and writes both sides
    send(0, 0, 16'h03FF, 0, 0);
    send(0, 0, 16'h0400, 0, 0);
    send(0, 1, 16'h0400, 8'hC7, 0);
    send(0, 0, 16'h0400, 0, 0);
    send(0, 1, 16'h0010, 8'h3E, 0);
    send(0, 0, 16'h0010, 0, 0);
    send(0, 1, 16'h8123, 8'h19, 2);
    send(0, 0, 16'h8123, 0, 0);
    // R10: write flag on fetches
    send(1, 1, 16'h0123, 8'hFF, 0);
    send(1, 1, 16'h5555, 8'hFF, 0);
    // R9: response back-pressure on both paths
    send(1, 0, 16'hA0A0, 0, 5);
    send(0, 0, 16'h0200, 0, 4);
    // R2: zero program size, reset vector goes out
    @(negedge clk); #1 code_size = 17'h0;
    send(1, 0, 16'h0000, 0, 0);
    send(1, 0, 16'h0001, 0, 1);
    // R11: full 64 KB sizes
    @(negedge clk); #1 code_size = 17'h10000; data_size = 17'h10000;
    send(1, 0, 16'hFFFF, 0, 0);
    send(0, 1, 16'hFFFF, 8'h77, 0);
    send(0, 0, 16'hFFFF, 0, 0);
    // R9: request held valid across busy periods
    @(negedge clk); #1 data_size = 17'h00400;
    rsp_ready = 1'b1;
    req_valid = 1'b1; req_code = 1'b0; req_write = 1'b0; req_addr = 16'h0401;
    repeat (15) @(negedge clk);
    #1 req_addr = 16'h0002;
    repeat (10) @(negedge clk);
    #1 req_valid = 1'b0;
    repeat (8) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule